// File: doc/BRIEF.md
# SAR ADC conversion controller

This block is the digital sequencer for a 10-bit successive-approximation converter serving up to eight multiplexed analog inputs. A 10 MHz system clock is divided by 6 (fast) or 12 (slow) into conversion ticks. Each tick advances the sequencer by one step. The sequencer runs an optional pre-charge phase, then a short sample window, then ten comparator decisions from the most significant bit down. It drives the DAC trial code and the mux select, and it reads back a single comparator bit.

Each finished conversion is written into that channel's own result register. The register is read as an 8-bit upper part and a 2-bit lower part. The analog section needs a number of throw-away conversions to settle its internal tuning. For this reason, a conversion only raises its channel's ready flag once twenty conversions have completed since reset. Control is level based: the run bit starts the block and holds it running, and clearing it stops the block at once.

Top module: `sar_adc_ctrl`

## Requirements
- R1: The ten result bits are decided MSB first, one per conversion tick. The first trial code is 0x200. A bit is kept when `cmp_in` is 1, meaning the input is at or above the trial code. The stored result is therefore the largest code not above the input.
- R2: Without pre-charge, one conversion keeps `busy` high for 12 ticks: 2 sample ticks and 10 decision ticks. A tick is 6 clocks when `cfg_slow`=0 and 12 clocks when `cfg_slow`=1.
- R3: When `cfg_no_prech`=0 at launch, `prech_o` is high for 16 ticks before sampling starts, and `busy` covers 28 ticks for one conversion.
- R4: When `cfg_no_prech`=1 at launch, the pre-charge phase is skipped and sampling starts in the first cycle after launch.
- R5: `tuned` goes high, and stays high, once 20 conversions have completed since reset. A completed conversion sets `ready[ch]` only if `tuned` was already high when it finished.
- R6: Each channel has its own result register. `rd_hi` returns bits 9..2 and `rd_lo` returns bits 1..0 of the channel chosen by `rd_sel`. All `ready` bits are cleared at launch.
- R7: With `cfg_seq`=1, channels 0 through `cfg_chan` are converted in ascending order, one after another without a gap. With `cfg_seq`=0, only channel `cfg_chan` is converted.
- R8: With `cfg_cont`=1, the conversion or sequence repeats for as long as `cfg_start` stays high. When `cfg_start` is low at a clock edge, `busy` is low after that edge. Without `cfg_cont`, the block waits with `busy` low until `cfg_start` is cleared.
- R9: `ref_ext_o` follows `cfg_ref_ext`.
- R10: After reset, `busy`, `tuned`, `ready`, `dac_code` and the result registers are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 10 MHz system clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_start | input | 1 | Run bit: launch and keep running |
| cfg_no_prech | input | 1 | Skip the pre-charge phase |
| cfg_slow | input | 1 | 1 selects divide-by-12, 0 selects divide-by-6 |
| cfg_ref_ext | input | 1 | Reference select, passed to the analog section |
| cfg_seq | input | 1 | Convert channels 0..cfg_chan in turn |
| cfg_cont | input | 1 | Repeat until the run bit is cleared |
| cfg_chan | input | 3 | Single channel, or last channel of a sequence |
| cmp_in | input | 1 | Comparator: input at or above DAC code |
| dac_code | output | 10 | Trial code for the DAC; zero outside decisions |
| mux_sel | output | 3 | Analog mux channel select |
| ref_ext_o | output | 1 | Reference select to the analog section |
| prech_o | output | 1 | Pre-charge phase active |
| sample_o | output | 1 | Sample-and-hold window active |
| busy | output | 1 | Pre-charge, sample or decision in progress |
| ready | output | 8 | Per-channel trusted-result flags |
| tuned | output | 1 | Warm-up conversion count reached |
| rd_sel | input | 3 | Channel to read |
| rd_hi | output | 8 | Result bits 9..2 of the selected channel |
| rd_lo | output | 2 | Result bits 1..0 of the selected channel |

## Verification
The assertions assume that the configuration bits other than `cfg_start` stay constant while the block is busy. The sequencing check also assumes that `cfg_seq` does not toggle during a run. The comparator is assumed to respond combinationally to `dac_code` and `mux_sel` within the same cycle. The stimulus respects these assumptions by changing configuration only while the block is idle. It drives all inputs on the falling edge, and it models the comparator as a plain compare between a stored per-channel input value and the DAC code.

// File: rtl/sar_adc_ctrl.sv
module sar_adc_ctrl #(
  parameter int CHANNELS     = 8,
  parameter int BITS         = 10,
  parameter int LO_BITS      = 2,
  parameter int DIV_FAST     = 6,
  parameter int DIV_SLOW     = 12,
  parameter int PRECH_TICKS  = 16,
  parameter int SAMPLE_TICKS = 2,
  parameter int TUNE_COUNT   = 20
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       cfg_start,
  input  logic                       cfg_no_prech,
  input  logic                       cfg_slow,
  input  logic                       cfg_ref_ext,
  input  logic                       cfg_seq,
  input  logic                       cfg_cont,
  input  logic [$clog2(CHANNELS)-1:0] cfg_chan,
  input  logic                       cmp_in,
  output logic [BITS-1:0]            dac_code,
  output logic [$clog2(CHANNELS)-1:0] mux_sel,
  output logic                       ref_ext_o,
  output logic                       prech_o,
  output logic                       sample_o,
  output logic                       busy,
  output logic [CHANNELS-1:0]        ready,
  output logic                       tuned,
  input  logic [$clog2(CHANNELS)-1:0] rd_sel,
  output logic [BITS-LO_BITS-1:0]    rd_hi,
  output logic [LO_BITS-1:0]         rd_lo
);
  localparam int CW = $clog2(CHANNELS);
  localparam int DW = $clog2(DIV_SLOW + 1);
  localparam int PMAX = (PRECH_TICKS > SAMPLE_TICKS) ? PRECH_TICKS : SAMPLE_TICKS;
  localparam int PW = $clog2(PMAX + 1);
  localparam int BW = $clog2(BITS);
  localparam int TW = $clog2(TUNE_COUNT + 1);

  typedef enum logic [2:0] {S_IDLE, S_PRECH, S_SAMPLE, S_CONV, S_HOLD} state_t;

  state_t          st;
  logic [DW-1:0]   div_cnt;
  logic [PW-1:0]   phase;
  logic [BW-1:0]   bit_idx;
  logic [BITS-1:0] sar;
  logic [CW-1:0]   chan;
  logic [TW-1:0]   tune_cnt;
  logic [BITS-1:0] res [CHANNELS];

  logic [DW-1:0]   div_last;
  logic            tick;
  logic [BITS-1:0] mask;
  logic [BITS-1:0] decided;
  logic [CW-1:0]   first_ch;
  logic            seq_end;

  assign div_last = cfg_slow ? DW'(DIV_SLOW - 1) : DW'(DIV_FAST - 1);
  assign busy     = (st == S_PRECH) || (st == S_SAMPLE) || (st == S_CONV);
  assign tick     = busy && (div_cnt >= div_last);
  assign mask     = BITS'(1) << bit_idx;
  assign decided  = cmp_in ? (sar | mask) : sar;
  assign first_ch = cfg_seq ? '0 : cfg_chan;
  assign seq_end  = !cfg_seq || (chan == cfg_chan);

  assign dac_code  = (st == S_CONV) ? (sar | mask) : '0;
  assign mux_sel   = chan;
  assign ref_ext_o = cfg_ref_ext;
  assign prech_o   = (st == S_PRECH);
  assign sample_o  = (st == S_SAMPLE);
  assign tuned     = (tune_cnt >= TW'(TUNE_COUNT));
  assign rd_hi     = res[rd_sel][BITS-1:LO_BITS];
  assign rd_lo     = res[rd_sel][LO_BITS-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n || !busy || tick) div_cnt <= '0;
    else                         div_cnt <= div_cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      phase    <= '0;
      bit_idx  <= '0;
      sar      <= '0;
      chan     <= '0;
      tune_cnt <= '0;
      ready    <= '0;
      for (int i = 0; i < CHANNELS; i++) res[i] <= '0;
    end else if (!cfg_start) begin
      st <= S_IDLE;
    end else begin
      case (st)
        S_IDLE: begin
          ready <= '0;
          chan  <= first_ch;
          phase <= '0;
          st    <= cfg_no_prech ? S_SAMPLE : S_PRECH;
        end
        S_PRECH: if (tick) begin
          if (phase == PW'(PRECH_TICKS - 1)) begin
            phase <= '0;
            st    <= S_SAMPLE;
          end else phase <= phase + 1'b1;
        end
        S_SAMPLE: if (tick) begin
          if (phase == PW'(SAMPLE_TICKS - 1)) begin
            phase   <= '0;
            sar     <= '0;
            bit_idx <= BW'(BITS - 1);
            st      <= S_CONV;
          end else phase <= phase + 1'b1;
        end
        S_CONV: if (tick) begin
          if (bit_idx == '0) begin
            res[chan] <= decided;
            if (tuned) ready[chan] <= 1'b1;
            else       tune_cnt <= tune_cnt + 1'b1;
            if (!seq_end) begin
              chan <= chan + 1'b1;
              st   <= S_SAMPLE;
            end else if (cfg_cont) begin
              chan <= first_ch;
              st   <= S_SAMPLE;
            end else st <= S_HOLD;
          end else begin
            sar     <= decided;
            bit_idx <= bit_idx - 1'b1;
          end
        end
        default: st <= S_HOLD;
      endcase
    end
  end
endmodule

module sar_adc_ctrl_chk #(
  parameter int CHANNELS = 8,
  parameter int BITS     = 10
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        cfg_start,
  input logic                        cfg_no_prech,
  input logic                        cfg_seq,
  input logic [BITS-1:0]             dac_code,
  input logic [$clog2(CHANNELS)-1:0] mux_sel,
  input logic                        prech_o,
  input logic                        sample_o,
  input logic                        busy,
  input logic [CHANNELS-1:0]         ready,
  input logic                        tuned
);
  assert_abort_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_start |=> !busy);

  assert_ready_tuned_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ready != '0) |-> tuned);

  assert_tuned_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    tuned |=> tuned);

  assert_prech_launch_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (prech_o == !$past(cfg_no_prech)));

  assert_skip_prech_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(busy) && $past(cfg_no_prech)) |-> sample_o);

  assert_first_trial_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(sample_o) && busy) |-> (dac_code == BITS'(1) << (BITS - 1)));

  assert_seq_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && $past(cfg_seq) && !$stable(mux_sel))
      |-> (mux_sel == ($past(mux_sel) + 1'b1) || mux_sel == '0));
endmodule

bind sar_adc_ctrl sar_adc_ctrl_chk #(.CHANNELS(CHANNELS), .BITS(BITS)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_start(cfg_start), .cfg_no_prech(cfg_no_prech),
  .cfg_seq(cfg_seq), .dac_code(dac_code), .mux_sel(mux_sel), .prech_o(prech_o),
  .sample_o(sample_o), .busy(busy), .ready(ready), .tuned(tuned)
);

// File: tb/sar_adc_ctrl_test.sv
module sar_adc_ctrl_test;
  logic clk = 0, rst_n = 0;
  logic cfg_start = 0, cfg_no_prech = 1, cfg_slow = 0, cfg_ref_ext = 0;
  logic cfg_seq = 0, cfg_cont = 0;
  logic [2:0] cfg_chan = 0, rd_sel = 0, mux_sel;
  logic cmp_in, ref_ext_o, prech_o, sample_o, busy, tuned;
  logic [9:0] dac_code;
  logic [7:0] ready, rd_hi;
  logic [1:0] rd_lo;
  logic [9:0] ain [8];

  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  assign cmp_in = (ain[mux_sel] >= dac_code);

  sar_adc_ctrl uut (
    .clk(clk), .rst_n(rst_n), .cfg_start(cfg_start), .cfg_no_prech(cfg_no_prech),
    .cfg_slow(cfg_slow), .cfg_ref_ext(cfg_ref_ext), .cfg_seq(cfg_seq),
    .cfg_cont(cfg_cont), .cfg_chan(cfg_chan), .cmp_in(cmp_in), .dac_code(dac_code),
    .mux_sel(mux_sel), .ref_ext_o(ref_ext_o), .prech_o(prech_o), .sample_o(sample_o),
    .busy(busy), .ready(ready), .tuned(tuned), .rd_sel(rd_sel), .rd_hi(rd_hi),
    .rd_lo(rd_lo)
  );

  // vector: {slow, channel, input value}
  localparam logic [13:0] VEC [8] = '{
    {1'b0, 3'd0, 10'd0},   {1'b0, 3'd7, 10'd1023}, {1'b1, 3'd3, 10'd512},
    {1'b0, 3'd5, 10'd511}, {1'b1, 3'd1, 10'd1},    {1'b0, 3'd2, 10'd682},
    {1'b1, 3'd6, 10'd341}, {1'b0, 3'd4, 10'd1022}
  };

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic run_count(output int nbusy, output int nprech);
    nbusy = 0; nprech = 0;
    cfg_start = 1;
    @(negedge clk);
    while (busy && nbusy < 5000) begin
      nbusy++;
      if (prech_o) nprech++;
      @(negedge clk);
    end
  endtask

  task automatic stop();
    cfg_start = 0;
    @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int nb, np;
    logic [9:0] r;
    for (int i = 0; i < 8; i++) ain[i] = 10'd100;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R10 reset state
    chk(!busy && !tuned, "R10 busy/tuned", {busy, tuned}, 0);
    chk(ready == 0, "R10 ready", ready, 0);
    chk(dac_code == 0, "R10 dac", dac_code, 0);
    chk(rd_hi == 0 && rd_lo == 0, "R10 result", {rd_hi, rd_lo}, 0);
    // R9
    cfg_ref_ext = 1; #1;
    chk(ref_ext_o == 1, "R9 ref", ref_ext_o, 1);
    cfg_ref_ext = 0; #1;
    chk(ref_ext_o == 0, "R9 ref", ref_ext_o, 0);

    // R5 warm-up: continuous single channel 0, 72 clocks per conversion
    ain[0] = 10'd300; cfg_chan = 0; cfg_cont = 1; cfg_no_prech = 1;
    cfg_start = 1;
    repeat (20 * 72) @(negedge clk);
    chk(!tuned, "R5 not tuned after 19", tuned, 0);
    @(negedge clk);
    chk(tuned, "R5 tuned after 20", tuned, 1);
    chk(ready == 0, "R5 20th not ready", ready, 0);
    repeat (72) @(negedge clk);
    chk(ready == 8'h01, "R5 21st ready", ready, 1);
    chk(busy, "R8 continuous busy", busy, 1);
    stop();
    chk(!busy, "R8 stop idle", busy, 0);
    cfg_cont = 0;

    // R1 R2 R6 vector walk
    foreach (VEC[k]) begin
      cfg_slow = VEC[k][13];
      cfg_chan = VEC[k][12:10];
      ain[VEC[k][12:10]] = VEC[k][9:0];
      run_count(nb, np);
      chk(nb == (VEC[k][13] ? 144 : 72), "R2 conversion length", nb, VEC[k][13] ? 144 : 72);
      rd_sel = VEC[k][12:10]; #1;
      r = {rd_hi, rd_lo};
      chk(r == VEC[k][9:0], "R1 R6 result", r, VEC[k][9:0]);
      chk(ready == (8'h01 << VEC[k][12:10]), "R6 ready one channel", ready, 8'h01 << VEC[k][12:10]);
      stop();
    end
    rd_sel = 3'd7; #1;
    chk(rd_hi == 8'hFF && rd_lo == 2'b11, "R6 split hi/lo", {rd_hi, rd_lo}, 1023);

    // R3 pre-charge
    cfg_slow = 0; cfg_no_prech = 0; cfg_chan = 5; ain[5] = 10'd777;
    run_count(nb, np);
    chk(np == 96, "R3 prech length", np, 96);
    chk(nb == 168, "R3 total with prech", nb, 168);
    rd_sel = 5; #1;
    chk({rd_hi, rd_lo} == 10'd777, "R3 result", {rd_hi, rd_lo}, 777);
    stop();
    // R4 skip
    cfg_no_prech = 1;
    cfg_start = 1;
    @(negedge clk);
    chk(sample_o && !prech_o, "R4 sampling at once", {sample_o, prech_o}, 2);
    stop();

    // R7 sequence 0..3
    ain[0] = 10'd11; ain[1] = 10'd222; ain[2] = 10'd733; ain[3] = 10'd1000;
    cfg_seq = 1; cfg_chan = 3;
    run_count(nb, np);
    chk(nb == 288, "R7 sequence length", nb, 288);
    chk(ready == 8'h0F, "R7 ready set", ready, 8'h0F);
    for (int c = 0; c < 4; c++) begin
      rd_sel = 3'(c); #1;
      chk({rd_hi, rd_lo} == ain[c], "R7 channel result", {rd_hi, rd_lo}, ain[c]);
    end
    stop();

    // R8 continuous sequence then abort mid-conversion
    cfg_cont = 1; cfg_chan = 1;
    cfg_start = 1;
    repeat (3 * 144 + 40) @(negedge clk);
    chk(busy, "R8 still running", busy, 1);
    chk(ready == 8'h03, "R8 ready repeated", ready, 8'h03);
    cfg_start = 0;
    @(negedge clk);
    chk(!busy && dac_code == 0, "R8 abort", {busy, dac_code}, 0);
    cfg_cont = 0; cfg_seq = 0;
    @(negedge clk);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule